// File: doc/BRIEF.md
# Packed-Decimal Accumulator Correction Unit

This block repairs an 8-bit accumulator after a plain binary add or subtract has been performed on two packed decimal operands, each byte holding two decimal digits. It takes the raw accumulator together with the carry, half-carry and add/subtract indicators that the arithmetic step left behind. From the digit values and those indicators it picks a correction constant and adds it modulo 256. It then produces the corrected byte, a new carry, and sign, zero and parity indicators. The add/subtract indicator passes through untouched.

After an addition the correction is one of 00, 06, 60 or 66 hex. A nibble is fixed by 6 when it went out of the decimal range or when a carry was reported out of it. After a subtraction the constant depends only on the incoming carry and half-carry, and the outgoing carry copies the incoming one. The correction path is purely combinational. A single register stage with a valid strobe captures the result so that a bench or a neighbouring pipeline can sample it. The block does not contain the binary adder that produced its input.

Top module: `dadj_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid, result and every output flag are 0.
- R2: Add mode (sub_in=0), cy_in=0, hc_in=0, accumulator at most 99 hex with low nibble A to F: the result is the accumulator plus 06 hex and cy_out is 0.
- R3: Add mode, cy_in=0, hc_in=0, both nibbles 0 to 9: the result equals the accumulator and cy_out is 0.
- R4: Add mode with cy_in=1 or accumulator above 99 hex: 60 hex is added (plus 06 hex if the low-nibble rule of R2/R5 also applies) and cy_out is 1.
- R5: Add mode, cy_in=0, hc_in=1, accumulator at most 99 hex: the result is the accumulator plus 06 hex and cy_out is 0.
- R6: Subtract mode (sub_in=1): the value added modulo 256 is 00, FA, A0 or 9A hex for {cy_in,hc_in} = 00, 01, 10, 11, and cy_out equals cy_in.
- R7: sign_out equals bit 7 of the result and zero_out is 1 exactly when the result is 00.
- R8: parity_out is 1 when the result holds an even number of 1 bits, 0 when odd.
- R9: sub_out equals the sub_in that was captured with the same sample.
- R10: Outputs update on the clock edge where in_valid is 1, out_valid is 1 in the following cycle only, and with in_valid at 0 the result and flags hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accumulator and indicators are valid this cycle |
| acc_in | input | 8 | Raw accumulator after binary arithmetic |
| cy_in | input | 1 | Carry left by the arithmetic step |
| hc_in | input | 1 | Half-carry (out of bit 3) left by the arithmetic step |
| sub_in | input | 1 | 1 if the arithmetic step was a subtraction |
| out_valid | output | 1 | Registered result is fresh this cycle |
| result | output | 8 | Corrected accumulator |
| cy_out | output | 1 | New carry |
| sign_out | output | 1 | Bit 7 of the result |
| zero_out | output | 1 | Result is zero |
| parity_out | output | 1 | Result has even parity |
| sub_out | output | 1 | Add/subtract indicator passed through |

## Verification
The bench sweeps all 256 accumulator values against all eight combinations of carry, half-carry and mode, 2048 samples in all. Each sample is labelled by the rule it falls under, so valid decimal bytes with clear indicators, out-of-range low digits, a raised half-carry, out-of-range high digits or an incoming carry, and each subtract-mode constant are all told apart. The range edges at low nibble 9/A and at 99/9A hex are covered by the sweep, as is 9A hex, which needs both corrections. Idle cycles with changing inputs show that the registered outputs hold.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int DIGIT_MAX = 9;
    localparam int DIGIT_FIX = 6;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NIB_W-1:0]  nib_t;

    typedef struct packed {
        byte_t acc;
        logic  cy;
        logic  hc;
        logic  sub;
    } dadj_in_t;

    typedef struct packed {
        byte_t res;
        logic  cy;
        logic  sign;
        logic  zero;
        logic  parity;
        logic  sub;
    } dadj_out_t;

    typedef enum logic [1:0] {
        FIX_NONE = 2'b00,
        FIX_LOW  = 2'b01,
        FIX_HIGH = 2'b10,
        FIX_BOTH = 2'b11
    } fix_sel_e;

    function automatic logic nib_over(input nib_t n);
        return n > nib_t'(DIGIT_MAX);
    endfunction

    function automatic logic byte_over(input byte_t b);
        return b > byte_t'(DIGIT_MAX * 16 + DIGIT_MAX);
    endfunction

    function automatic byte_t fix_value(input fix_sel_e sel);
        byte_t v;
        v = '0;
        if (sel[0]) v[NIB_W-1:0]      = nib_t'(DIGIT_FIX);
        if (sel[1]) v[BYTE_W-1:NIB_W] = nib_t'(DIGIT_FIX);
        return v;
    endfunction

endpackage

// File: rtl/dadj_add_corr.sv
module dadj_add_corr
    import dadj_pkg::*;
(
    input  byte_t acc,
    input  logic  cy,
    input  logic  hc,
    output byte_t corr,
    output logic  cy_next
);
    fix_sel_e sel;

    always_comb begin
        sel = FIX_NONE;
        if (hc || nib_over(acc[NIB_W-1:0])) sel = fix_sel_e'(sel | FIX_LOW);
        if (cy || byte_over(acc))           sel = fix_sel_e'(sel | FIX_HIGH);
        corr    = fix_value(sel);
        cy_next = sel[1];
    end
endmodule

// File: rtl/dadj_sub_corr.sv
module dadj_sub_corr
    import dadj_pkg::*;
(
    input  logic  cy,
    input  logic  hc,
    output byte_t corr,
    output logic  cy_next
);
    fix_sel_e sel;
    byte_t    mag;

    always_comb begin
        sel     = fix_sel_e'({cy, hc});
        mag     = fix_value(sel);
        corr    = byte_t'(~mag + byte_t'(1));
        cy_next = cy;
    end
endmodule

// File: rtl/dadj_flag_gen.sv
module dadj_flag_gen
    import dadj_pkg::*;
(
    input  byte_t res,
    output logic  sign,
    output logic  zero,
    output logic  parity
);
    always_comb begin
        sign   = res[BYTE_W-1];
        zero   = (res == '0);
        parity = ~^res;
    end
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
    import dadj_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] acc_in,
    input  logic              cy_in,
    input  logic              hc_in,
    input  logic              sub_in,
    output logic              out_valid,
    output logic [BYTE_W-1:0] result,
    output logic              cy_out,
    output logic              sign_out,
    output logic              zero_out,
    output logic              parity_out,
    output logic              sub_out
);
    dadj_in_t  din;
    dadj_out_t nxt, q;
    byte_t     add_corr, sub_corr, corr;
    logic      add_cy, sub_cy;
    logic      f_sign, f_zero, f_par;
    logic      vld_q;

    assign din = '{acc: acc_in, cy: cy_in, hc: hc_in, sub: sub_in};

    dadj_add_corr u_add (
        .acc     (din.acc),
        .cy      (din.cy),
        .hc      (din.hc),
        .corr    (add_corr),
        .cy_next (add_cy)
    );

    dadj_sub_corr u_sub (
        .cy      (din.cy),
        .hc      (din.hc),
        .corr    (sub_corr),
        .cy_next (sub_cy)
    );

    assign corr = din.sub ? sub_corr : add_corr;

    dadj_flag_gen u_flags (
        .res    (nxt.res),
        .sign   (f_sign),
        .zero   (f_zero),
        .parity (f_par)
    );

    always_comb begin
        nxt.res    = byte_t'(din.acc + corr);
        nxt.cy     = din.sub ? sub_cy : add_cy;
        nxt.sign   = f_sign;
        nxt.zero   = f_zero;
        nxt.parity = f_par;
        nxt.sub    = din.sub;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) q <= nxt;
        end
    end

    assign out_valid  = vld_q;
    assign result     = q.res;
    assign cy_out     = q.cy;
    assign sign_out   = q.sign;
    assign zero_out   = q.zero;
    assign parity_out = q.parity;
    assign sub_out    = q.sub;
endmodule

// File: rtl/dadj_chk.sv
module dadj_chk
    import dadj_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [BYTE_W-1:0] acc_in,
    input logic              cy_in,
    input logic              hc_in,
    input logic              sub_in,
    input logic              out_valid,
    input logic [BYTE_W-1:0] result,
    input logic              cy_out,
    input logic              sign_out,
    input logic              zero_out,
    input logic              parity_out,
    input logic              sub_out
);
    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(result) && $stable(cy_out));

    // R6
    sub_carry_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && sub_in |=> cy_out == $past(cy_in));

    // R4
    add_carry_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && !sub_in && cy_in |=> cy_out);

    // R3
    add_clean_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && !sub_in && !cy_in && !hc_in &&
        (acc_in[3:0] < 4'hA) && (acc_in[7:4] < 4'hA)
        |=> result == $past(acc_in) && !cy_out);

    // R9
    mode_pass_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> sub_out == $past(sub_in));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> zero_out == (result == 8'h00) && sign_out == result[7]);

    // R8
    parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> parity_out == ($countones(result) % 2 == 0));
endmodule

bind dadj_unit dadj_chk u_chk (.*);

// File: tb/tb_dadj_unit.sv
module tb_dadj_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] acc_in;
    logic       cy_in, hc_in, sub_in;
    logic       out_valid;
    logic [7:0] result;
    logic       cy_out, sign_out, zero_out, parity_out, sub_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dadj_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .acc_in(acc_in),
        .cy_in(cy_in), .hc_in(hc_in), .sub_in(sub_in),
        .out_valid(out_valid), .result(result), .cy_out(cy_out),
        .sign_out(sign_out), .zero_out(zero_out),
        .parity_out(parity_out), .sub_out(sub_out)
    );

    task automatic check(input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
        end
    endtask

    function automatic string rule_of(input logic [7:0] a, input logic c,
                                      input logic h, input logic s);
        if (s)                   return "R6";
        if (c || a > 8'h99)      return "R4";
        if (h)                   return "R5";
        if (a[3:0] > 4'd9)       return "R2";
        return "R3";
    endfunction

    task automatic run_one(input logic [7:0] a, input logic c,
                           input logic h, input logic s);
        int    exp_res, ones;
        bit    exp_cy;
        string req;
        @(negedge clk);
        in_valid = 1'b1; acc_in = a; cy_in = c; hc_in = h; sub_in = s;
        if (s) begin
            exp_res = (int'(a) - (c ? 96 : 0) - (h ? 6 : 0) + 256) % 256;
            exp_cy  = c;
        end else begin
            exp_res = int'(a);
            if (h || a[3:0] > 4'd9) exp_res += 6;
            if (c || a > 8'h99)     exp_res += 96;
            exp_res = exp_res % 256;
            exp_cy  = c || (a > 8'h99);
        end
        req = rule_of(a, c, h, s);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "result", int'(result), exp_res);
        check(req, "carry", int'(cy_out), int'(exp_cy));
        ones = 0;
        for (int b = 0; b < 8; b++) ones += (exp_res >> b) & 1;
        check("R7", "sign", int'(sign_out), (exp_res >> 7) & 1);
        check("R7", "zero", int'(zero_out), int'(exp_res == 0));
        check("R8", "parity", int'(parity_out), int'(ones % 2 == 0));
        check("R9", "mode", int'(sub_out), int'(s));
        check("R10", "valid", int'(out_valid), 1);
    endtask

    initial begin
        logic [7:0] held;
        rst = 1'b1; in_valid = 1'b0; acc_in = 8'h00;
        cy_in = 1'b0; hc_in = 1'b0; sub_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", int'(out_valid), 0);
        check("R1", "result in reset", int'(result), 0);
        check("R1", "flags in reset",
              int'({cy_out, sign_out, zero_out, parity_out, sub_out}), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "valid after reset", int'(out_valid), 0);
        check("R1", "result after reset", int'(result), 0);

        for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < 256; a++) begin
                run_one(8'(a), m[2], m[1], m[0]);
            end
        end

        // R10: idle cycles with changing inputs leave outputs alone
        run_one(8'h9A, 1'b0, 1'b0, 1'b0);
        held = result;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            acc_in = 8'(k * 37 + 5); cy_in = k[0]; hc_in = k[1]; sub_in = ~k[0];
            check("R10", "valid idle", int'(out_valid), 0);
            check("R10", "result idle", int'(result), int'(held));
            check("R10", "carry idle", int'(cy_out), 1);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule